// File: doc/BRIEF.md
# Hashed page table group searcher

This block walks one group of eight page-table entries held in memory and looks for the entry that matches a compare tag prepared by the caller. The caller supplies the group base address, the hash-select bit naming the primary or secondary group, the compare tag, the access direction and the entry format. The format is either a narrow layout with 32-bit words or a wide layout with 64-bit words. The block fetches words through a request/response memory port with one read in flight at a time. At the end it reports a hit, a miss or an inconsistency. On a hit it also gives the index of the matching entry and the entry's second word.

The search always runs across the whole group, so several matching entries can be compared with each other. If two matches disagree in their translation fields, the search stops with an inconsistency result. On a hit the referenced flag is set, and on a write hit the changed flag is set as well. The second word is written back to memory only when one of these flags actually changes. The tag computation, protection-key handling and any translation caching sit outside this block.

Top module: `hpt_group_search`

## Requirements
- R1: A start pulse accepted while idle reads the first word of entries 0 to 7 in increasing index order, at base + i*8 in narrow mode and at base + i*16 in wide mode. At most one read is outstanding, and a request is held with a stable address until the port accepts it.
- R2: The second word of an entry is read only when that entry is a candidate. It is read at entry address + 4 in narrow mode and + 8 in wide mode, using response bits 31:0 in narrow mode and all 64 bits in wide mode.
- R3: Narrow mode (mode64 = 0): an entry is a candidate when bit 31 of word 0 is 1 (valid), bit 6 equals hsel, and word 0 AND 0x7FFFFFBF equals the tag.
- R4: Wide mode (mode64 = 1): an entry is a candidate when bit 0 of word 0 is 1 (valid), bit 1 equals hsel, and word 0 AND 0xFFFFFFFFFFFFFF80 equals the tag. Bits 6:2 of word 0 have no effect on the result.
- R5: The scan continues past the first candidate to entry 7. The reported index and second word are those of the first candidate.
- R6: A later candidate whose second word differs from the first candidate's under the agreement mask ends the search at once with result 2 and no write-back. The agreement mask is the page-frame bits (bit PAGE_BITS and above) OR 0x7B in narrow mode, and OR 0x7F in wide mode.
- R7: Candidates that differ only outside the agreement mask, such as the referenced bit 8 and the changed bit 7, do not cause an error.
- R8: On a hit the reported second word has the referenced bit (bit 8) set. It also has the changed bit (bit 7) set when is_write is 1.
- R9: On a hit a write of the updated second word goes to the first candidate's second-word address before done, and only if bit 8 or bit 7 changed.
- R10: done is a one-cycle pulse that comes with result 0 (hit), 1 (miss, no candidate) or 2 (inconsistency).
- R11: While reset is high and in the cycle after it, no memory request is presented and done is low. A search interrupted by reset never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when idle |
| mode64 | input | 1 | 1 selects the wide entry format |
| hsel | input | 1 | Requested hash-select value |
| is_write | input | 1 | Access is a store |
| base_addr | input | ADDR_W | Byte address of the group |
| cmp_tag | input | 64 | Compare tag (low 32 bits in narrow mode) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | 64 | Write data (low 32 bits in narrow mode) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 hit, 1 miss, 2 inconsistency |
| hit_index | output | IDX_W | Index of the first candidate |
| hit_word1 | output | 64 | Updated second word of the first candidate |

## Verification
The hardest case to reach from the ports is a group holding two matching entries. They have to either clash in a translation field or differ only in the history flags, so the inconsistency path and its tolerance both get exercised. The bench builds such groups directly in its memory model. It places the two candidates at chosen indices in both formats. It then counts the reads issued, which shows that the scan stopped right at the clash and did not write back. A memory port that refuses a request every third cycle keeps the hold-and-wait handshake in use throughout.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam logic [1:0] RES_HIT  = 2'd0;
  localparam logic [1:0] RES_MISS = 2'd1;
  localparam logic [1:0] RES_ERR  = 2'd2;

  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;

  localparam logic [63:0] TAG_MASK_N = 64'h0000_0000_7FFF_FFBF;
  localparam logic [63:0] TAG_MASK_W = 64'hFFFF_FFFF_FFFF_FF80;
  localparam logic [63:0] ATTR_N     = 64'h7B;
  localparam logic [63:0] ATTR_W     = 64'h7F;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_END} hpt_state_e;
endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              mode64,
  input  logic              second,
  output logic [ADDR_W-1:0] addr
);
  localparam int SH_N   = 3;
  localparam int SH_W   = 4;
  localparam int WOFF_N = 4;
  localparam int WOFF_W = 8;

  logic [ADDR_W-1:0] ent_off, word_off;

  always_comb begin
    ent_off  = mode64 ? (ADDR_W'(idx) << SH_W) : (ADDR_W'(idx) << SH_N);
    word_off = !second ? '0 : (mode64 ? ADDR_W'(WOFF_W) : ADDR_W'(WOFF_N));
    addr     = base + ent_off + word_off;
  end
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
  import hpt_pkg::*;
(
  input  logic [63:0] word0,
  input  logic [63:0] tag,
  input  logic        mode64,
  input  logic        hsel,
  output logic        cand
);
  logic [63:0] w0_eff, tag_eff, mask;
  logic        vld, hbit;

  always_comb begin
    w0_eff  = mode64 ? word0 : {32'b0, word0[31:0]};
    tag_eff = mode64 ? tag   : {32'b0, tag[31:0]};
    mask    = mode64 ? TAG_MASK_W : TAG_MASK_N;
    vld     = mode64 ? word0[0] : word0[31];
    hbit    = mode64 ? word0[1] : word0[6];
    cand    = vld && (hbit == hsel) && ((w0_eff & mask) == tag_eff);
  end
endmodule

// File: rtl/hpt_flag_update.sv
module hpt_flag_update
  import hpt_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic [63:0] ref_w1,
  input  logic [63:0] cand_w1,
  input  logic        mode64,
  input  logic        is_write,
  output logic        agree,
  output logic [63:0] upd_w1,
  output logic        changed
);
  localparam logic [63:0] PF_MASK = ~((64'd1 << PAGE_BITS) - 64'd1);

  logic [63:0] amask, cand_eff;

  always_comb begin
    amask = PF_MASK | (mode64 ? ATTR_W : ATTR_N);
    if (!mode64) amask = amask & 64'h0000_0000_FFFF_FFFF;
    cand_eff = mode64 ? cand_w1 : {32'b0, cand_w1[31:0]};
    agree    = ((ref_w1 & amask) == (cand_eff & amask));
    upd_w1   = ref_w1;
    upd_w1[REF_BIT] = 1'b1;
    if (is_write) upd_w1[CHG_BIT] = 1'b1;
    changed  = (upd_w1 != ref_w1);
  end
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
  import hpt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GROUP_N   = 8,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = $clog2(GROUP_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode64,
  input  logic              hsel,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [63:0]       cmp_tag,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              done,
  output logic [1:0]        result,
  output logic [IDX_W-1:0]  hit_index,
  output logic [63:0]       hit_word1
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(GROUP_N - 1);

  hpt_state_e        state, state_n;
  logic              l_mode, l_hsel, l_wr;
  logic [ADDR_W-1:0] l_base;
  logic [63:0]       l_tag;
  logic [IDX_W-1:0]  idx, hit_idx_q;
  logic              sec, have_hit;
  logic [63:0]       hit_w1_q;

  logic              iss, iss_sec, iss_we, fin, acc;
  logic [IDX_W-1:0]  iss_idx;
  logic [1:0]        fin_res;

  logic              cand, agree, changed;
  logic [63:0]       upd_w1;
  logic [ADDR_W-1:0] ag_base, ag_addr;
  logic              ag_mode;

  hpt_entry_match u_match (
    .word0 (mem_rsp_data),
    .tag   (l_tag),
    .mode64(l_mode),
    .hsel  (l_hsel),
    .cand  (cand)
  );

  hpt_flag_update #(.PAGE_BITS(PAGE_BITS)) u_flag (
    .ref_w1  (hit_w1_q),
    .cand_w1 (mem_rsp_data),
    .mode64  (l_mode),
    .is_write(l_wr),
    .agree   (agree),
    .upd_w1  (upd_w1),
    .changed (changed)
  );

  assign ag_base = (state == ST_IDLE) ? base_addr : l_base;
  assign ag_mode = (state == ST_IDLE) ? mode64    : l_mode;

  hpt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
    .base  (ag_base),
    .idx   (iss_idx),
    .mode64(ag_mode),
    .second(iss_sec),
    .addr  (ag_addr)
  );

  always_comb begin
    state_n = state;
    iss     = 1'b0;
    iss_idx = idx;
    iss_sec = 1'b0;
    iss_we  = 1'b0;
    fin     = 1'b0;
    fin_res = RES_MISS;
    acc     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          iss     = 1'b1;
          iss_idx = '0;
          state_n = ST_REQ;
        end
      end
      ST_REQ: begin
        if (mem_req_ready) begin
          if (mem_req_we) begin
            fin     = 1'b1;
            fin_res = RES_HIT;
            state_n = ST_IDLE;
          end else begin
            state_n = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!sec && cand) begin
            iss     = 1'b1;
            iss_sec = 1'b1;
            state_n = ST_REQ;
          end else if (sec && have_hit && !agree) begin
            fin     = 1'b1;
            fin_res = RES_ERR;
            state_n = ST_IDLE;
          end else begin
            acc = sec && !have_hit;
            if (idx == LAST) begin
              state_n = ST_END;
            end else begin
              iss     = 1'b1;
              iss_idx = idx + 1'b1;
              state_n = ST_REQ;
            end
          end
        end
      end
      ST_END: begin
        if (!have_hit) begin
          fin     = 1'b1;
          fin_res = RES_MISS;
          state_n = ST_IDLE;
        end else if (changed) begin
          iss     = 1'b1;
          iss_we  = 1'b1;
          iss_idx = hit_idx_q;
          iss_sec = 1'b1;
          state_n = ST_REQ;
        end else begin
          fin     = 1'b1;
          fin_res = RES_HIT;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      done          <= 1'b0;
      result        <= RES_MISS;
      have_hit      <= 1'b0;
      idx           <= '0;
      sec           <= 1'b0;
    end else begin
      state <= state_n;
      done  <= fin;
      if (fin) result <= fin_res;
      if (state == ST_IDLE && start) begin
        l_mode   <= mode64;
        l_hsel   <= hsel;
        l_wr     <= is_write;
        l_base   <= base_addr;
        l_tag    <= cmp_tag;
        have_hit <= 1'b0;
      end
      if (iss) begin
        mem_req_valid <= 1'b1;
        mem_req_addr  <= ag_addr;
        mem_req_we    <= iss_we;
        mem_req_wdata <= upd_w1;
        idx           <= iss_idx;
        sec           <= iss_sec;
      end else if (state == ST_REQ && mem_req_ready) begin
        mem_req_valid <= 1'b0;
      end
      if (acc) begin
        have_hit  <= 1'b1;
        hit_idx_q <= idx;
        hit_w1_q  <= l_mode ? mem_rsp_data : {32'b0, mem_rsp_data[31:0]};
      end
      if (state == ST_END && have_hit) hit_w1_q <= upd_w1;
    end
  end

  assign hit_index = hit_idx_q;
  assign hit_word1 = hit_w1_q;
endmodule

// File: rtl/hpt_group_search_chk.sv
module hpt_group_search_chk
  import hpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              wdata_ref,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic [1:0]        result,
  input logic              hit_ref
);
  logic rd_out, wrote;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_out <= 1'b0;
      wrote  <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_req_we) rd_out <= 1'b1;
      else if (mem_rsp_valid) rd_out <= 1'b0;
      if (done) wrote <= 1'b0;
      else if (mem_req_valid && mem_req_ready && mem_req_we) wrote <= 1'b1;
    end
  end

  a_r11_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!mem_req_valid && !done));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_code_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != 2'd3));

  a_r1_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    rd_out |-> !mem_req_valid);

  a_r6_no_wb_unless_hit: assert property (@(posedge clk) disable iff (rst)
    (done && result != RES_HIT) |-> !wrote);

  a_r8_ref_on_hit: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_HIT) |-> hit_ref);

  a_r9_wb_carries_ref: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |-> wdata_ref);
endmodule

bind hpt_group_search hpt_group_search_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_we   (mem_req_we),
  .mem_req_addr (mem_req_addr),
  .wdata_ref    (mem_req_wdata[8]),
  .mem_rsp_valid(mem_rsp_valid),
  .done         (done),
  .result       (result),
  .hit_ref      (hit_word1[8])
);

// File: tb/sim_hpt_group_search.sv
module sim_hpt_group_search;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int NV = 12;
  localparam logic [AW-1:0] BASE = 32'h200;
  localparam logic [63:0] TAG_N = 64'h1234_5600;
  localparam logic [63:0] TAG_W = 64'h0ABC_DEF0_1234_5680;
  localparam logic [63:0] W1_N  = 64'h0004_5012;
  localparam logic [63:0] W1_W  = 64'h0000_0001_0004_5012;

  // {mode64, hsel, wr, scen[2:0], res[1:0], idx[2:0], wb, reads[3:0]}
  localparam logic [15:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,1'b0,3'd0,2'd0,3'd3,1'b1,4'd9},
    {1'b1,1'b1,1'b1,3'd0,2'd0,3'd3,1'b1,4'd9},
    {1'b0,1'b0,1'b0,3'd1,2'd1,3'd0,1'b0,4'd8},
    {1'b1,1'b0,1'b0,3'd1,2'd1,3'd0,1'b0,4'd8},
    {1'b0,1'b1,1'b0,3'd2,2'd0,3'd1,1'b1,4'd10},
    {1'b0,1'b0,1'b0,3'd3,2'd2,3'd0,1'b0,4'd7},
    {1'b1,1'b0,1'b1,3'd3,2'd2,3'd0,1'b0,4'd7},
    {1'b1,1'b0,1'b1,3'd4,2'd0,3'd1,1'b1,4'd10},
    {1'b0,1'b0,1'b0,3'd5,2'd0,3'd7,1'b0,4'd9},
    {1'b1,1'b0,1'b1,3'd5,2'd0,3'd7,1'b1,4'd9},
    {1'b0,1'b1,1'b0,3'd6,2'd1,3'd0,1'b0,4'd8},
    {1'b1,1'b1,1'b0,3'd7,2'd0,3'd4,1'b1,4'd9}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, start = 1'b0, mode64 = 1'b0, hsel = 1'b0, is_write = 1'b0;
  logic [AW-1:0] base_addr = BASE;
  logic [63:0]   cmp_tag = '0;
  logic          mem_req_valid, mem_req_we, done;
  logic          mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [63:0]   mem_req_wdata, hit_word1;
  logic [63:0]   mem_rsp_data = '0;
  logic [1:0]    result;
  logic [IW-1:0] hit_index;

  hpt_group_search u0 (
    .clk(clk), .rst(rst), .start(start), .mode64(mode64), .hsel(hsel),
    .is_write(is_write), .base_addr(base_addr), .cmp_tag(cmp_tag),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .result(result),
    .hit_index(hit_index), .hit_word1(hit_word1)
  );

  logic [31:0]   mem [0:255];
  logic [31:0]   cyc = 0;
  logic          fill_we = 1'b0, cnt_clr = 1'b0;
  logic [7:0]    fill_wi = '0;
  logic [31:0]   fill_d = '0;
  int            rd_cnt = 0;
  logic [AW-1:0] last_rd = '0;
  logic [7:0]    wi;
  assign wi = mem_req_addr[9:2];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 2;
    mem_rsp_valid <= 1'b0;
    if (cnt_clr) rd_cnt <= 0;
    if (fill_we) mem[fill_wi] <= fill_d;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[wi] <= mem_req_wdata[31:0];
        if (mode64) mem[wi + 8'd1] <= mem_req_wdata[63:32];
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= {mem[wi + 8'd1], mem[wi]};
        rd_cnt        <= rd_cnt + 1;
        last_rd       <= mem_req_addr;
      end
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int w, input logic [31:0] d);
    @(negedge clk);
    fill_we = 1'b1; fill_wi = 8'(w); fill_d = d;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  function automatic logic [63:0] w0f(input logic m, input logic v, input logic h, input logic [63:0] t);
    if (m) return (t & 64'hFFFF_FFFF_FFFF_FF80) | {62'b0, h, v};
    return (t & 64'h7FFF_FFBF) | (64'(v) << 31) | (64'(h) << 6);
  endfunction

  task automatic place(input int i, input logic m, input logic [63:0] w0, input logic [63:0] w1);
    if (m) begin
      poke(128 + i*4, w0[31:0]); poke(129 + i*4, w0[63:32]);
      poke(130 + i*4, w1[31:0]); poke(131 + i*4, w1[63:32]);
    end else begin
      poke(128 + i*2, w0[31:0]); poke(129 + i*2, w1[31:0]);
    end
  endtask

  function automatic logic [63:0] peek_w1(input int i, input logic m);
    if (m) return {mem[131 + i*4], mem[130 + i*4]};
    return {32'b0, mem[129 + i*2]};
  endfunction

  task automatic build(input int s, input logic m, input logic h);
    logic [63:0] t, w1;
    t  = m ? TAG_W : TAG_N;
    w1 = m ? W1_W : W1_N;
    for (int k = 128; k < 160; k++) poke(k, 32'h0);
    case (s)
      0: place(3, m, w0f(m, 1'b1, h, t), w1);
      1: begin
        place(2, m, w0f(m, 1'b1, !h, t), w1);
        place(5, m, w0f(m, 1'b1, h, t ^ 64'h1_0000), w1);
      end
      2: begin place(1, m, w0f(m, 1'b1, h, t), w1); place(6, m, w0f(m, 1'b1, h, t), w1); end
      3: begin place(2, m, w0f(m, 1'b1, h, t), w1); place(4, m, w0f(m, 1'b1, h, t), w1 ^ 64'h1000); end
      4: begin place(1, m, w0f(m, 1'b1, h, t), w1); place(6, m, w0f(m, 1'b1, h, t), w1 | 64'h180); end
      5: place(7, m, w0f(m, 1'b1, h, t), w1 | 64'h100);
      6: place(0, m, w0f(m, 1'b0, h, t), w1);
      default: place(4, m, w0f(m, 1'b1, h, t) | 64'h7C, w1);
    endcase
  endtask

  task automatic launch(input logic m, input logic h, input logic w);
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    mode64 = m; hsel = h; is_write = w; base_addr = BASE;
    cmp_tag = m ? TAG_W : TAG_N;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output logic got);
    got = 1'b0;
    for (int n = 0; n < 3000 && !got; n++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic got;
    logic m, h, w, wb;
    int s, ei, erd, stride;
    logic [1:0] eres;
    logic [63:0] orig, enew, w1b;
    string mt;

    repeat (3) @(negedge clk);
    chk(!done && !mem_req_valid, "R11 reset quiet", {62'b0, done, mem_req_valid}, 64'h0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      m = VEC[v][15]; h = VEC[v][14]; w = VEC[v][13];
      s = int'(VEC[v][12:10]); eres = VEC[v][9:8]; ei = int'(VEC[v][7:5]);
      wb = VEC[v][4]; erd = int'(VEC[v][3:0]);
      mt = m ? "R4" : "R3";
      stride = m ? 16 : 8;
      w1b  = m ? W1_W : W1_N;
      orig = (s == 5) ? (w1b | 64'h100) : w1b;
      enew = orig | 64'h100 | (w ? 64'h80 : 64'h0);
      build(s, m, h);
      launch(m, h, w);
      wait_done(got);
      chk(got, "R10 done seen", {63'b0, got}, 64'h1);
      chk(result == eres, $sformatf("R10/%s result vec %0d", mt, v), 64'(result), 64'(eres));
      chk(rd_cnt == erd, $sformatf("R2/R5 read count vec %0d", v), 64'(rd_cnt), 64'(erd));
      if (eres == 2'd0) begin
        chk(int'(hit_index) == ei, $sformatf("R5 index vec %0d", v), 64'(hit_index), 64'(ei));
        chk(hit_word1 == enew, $sformatf("R8 word1 vec %0d", v), hit_word1, enew);
        chk(peek_w1(ei, m) == (wb ? enew : orig), $sformatf("R9 memory vec %0d", v),
            peek_w1(ei, m), wb ? enew : orig);
        if (s == 4) chk(result == 2'd0, "R7 flag-only difference", 64'(result), 64'h0);
      end else if (eres == 2'd1) begin
        chk(last_rd == BASE + AW'(7 * stride), $sformatf("R1 last read vec %0d", v),
            64'(last_rd), 64'(BASE + AW'(7 * stride)));
      end else begin
        chk(peek_w1(2, m) == w1b, $sformatf("R6 no write-back vec %0d", v), peek_w1(2, m), w1b);
      end
    end

    // R11: reset in the middle of a search
    build(0, 1'b0, 1'b0);
    launch(1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req_valid, "R11 reset mid-search", {62'b0, done, mem_req_valid}, 64'h0);
    @(negedge clk);
    rst = 1'b0;
    got = 1'b0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (done || mem_req_valid) got = 1'b1;
    end
    chk(!got, "R11 no stale completion", {63'b0, got}, 64'h0);
    launch(1'b0, 1'b0, 1'b0);
    wait_done(got);
    chk(got && result == 2'd0 && hit_index == 3'd3, "R11 recovery hit", 64'(result), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule